// File: doc/BRIEF.md
# Bidirectional 12-bit Serial Link Endpoint

This block is one end of a point-to-point link that moves 12-bit words over a single serial lane. A run-time direction input picks its role. In the sending role it captures a parallel word on a strobe and sends it most significant bit first, one bit per cycle. The bits travel with a qualifying bit clock and a frame pulse on the first bit. In the receiving role it collects bits that are qualified by the incoming bit clock. A frame pulse marks the first bit of each word. When a word is complete, the block shows it on the parallel output and raises a word-clock pulse.

A two-bit select input either powers the block down or enables it. The three enabled codes act the same here, because the clock-range tuning they pick lives outside this block. The block drives the inverse of its direction input onto a direction output. Feeding that output to a peer's direction input makes the two ends always take opposite roles. The parallel output keeps its last received word across turnarounds and power-down, and an output-enable models the shared pins as tri-state.

In the sending role a one-word holding register absorbs a strobe that arrives while a word is still being sent. A sticky flag records a strobe that found both the shifter and the holding register full.

Top module: `duplex_serdes`

## Requirements
- R1: `dirOut` is the logical inverse of `dirIn` at all times, in every select code and during reset, with no clock involved.
- R2: With `selMode` = 00 the block is powered down. `serOut`, `serClkFwd`, `serFrame`, `wordClk` and `parOe` stay 0. Strobes and serial input have no effect, `parOut` is unchanged and `overrun` is cleared.
- R3: `parOe` is 1 exactly when `dirIn` = 0 and `selMode` is not 00.
- R4: Sending role (`dirIn` = 1): a strobe seen at a clock edge while idle captures `parIn`. During the next 12 cycles `serClkFwd` = 1 and `serOut` carries the word MSB first. `serFrame` = 1 during the first bit only.
- R5: `wordClk` is a one-cycle pulse. In the sending role it comes in the cycle after a word's last bit. In the receiving role it comes in the cycle after the edge that takes in a word's 12th bit.
- R6: A strobe during sending, with the holding register empty, queues `parIn`. The queued word's first bit follows the previous word's last bit with no idle cycle, so the frame pulses are 12 cycles apart.
- R7: A strobe during sending with the holding register full sets `overrun`, and that word is dropped. `overrun` stays set until power-down or reset. The exception is a strobe during the last bit cycle: the queued word moves into the shifter and the new word is queued, without setting `overrun`.
- R8: Receiving role (`dirIn` = 0): an edge with `serInClk` = 1 and `serInFrame` = 1 starts a word, and that bit becomes the MSB. The next 11 edges with `serInClk` = 1 and `serInFrame` = 0 supply the remaining bits in order. Edges with `serInClk` = 0 are ignored whatever `serIn` and `serInFrame` are.
- R9: Qualified bits that arrive when no word is open are ignored. A frame bit in the middle of a word drops the partial word and starts a new one.
- R10: `parOut` resets to 0. It changes only when a received word completes, and it holds its value through the sending role and through power-down.
- R11: Select codes 01, 10 and 11 produce identical behaviour.
- R12: Leaving the sending role (a change of direction or power-down) aborts the word being sent and empties the holding register. No `wordClk` pulse is given for it, and nothing is sent on return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial lane runs at one bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| dirIn | input | 1 | Role select: 1 sending, 0 receiving |
| selMode | input | 2 | 00 power-down, any other value enabled |
| strobe | input | 1 | Captures `parIn` for sending |
| parIn | input | 12 | Parallel word to send |
| parOut | output | 12 | Last received word |
| parOe | output | 1 | Output enable for the shared parallel pins |
| serOut | output | 1 | Serial data out |
| serClkFwd | output | 1 | Forwarded bit-clock qualifier, 1 for each valid sent bit |
| serFrame | output | 1 | First-bit marker of a sent word |
| serIn | input | 1 | Serial data in |
| serInClk | input | 1 | Received bit-clock qualifier |
| serInFrame | input | 1 | First-bit marker of a received word |
| wordClk | output | 1 | One-cycle completed-word pulse |
| overrun | output | 1 | Sticky flag for a dropped strobe |
| dirOut | output | 1 | Inverse of `dirIn` for the peer |

## Verification
The sending side is tried with a lone strobe, with two back-to-back strobes, and with three. The first pattern checks bit order and framing. The second shows that a queued word has no gap before it. The third tells a queued strobe apart from a dropped one. A strobe placed in the last bit cycle with a full queue separates that boundary from the true overrun case. Random strobe traffic is compared word by word against a bench queue. The receiving side gets words with random gaps, during which the qualifier is low and the data and frame lines carry junk. Stray unframed bits and a restart in mid-word are applied as well. Turnaround, power-down and changes of select code are interleaved to show that the held word and the inverse direction output follow the role and nothing else.

// File: rtl/serdes12_pkg.sv
`timescale 1ns/1ps
package serdes12_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic txClear;     // flush sending state
    logic txLoadPar;   // shifter <= parallel input
    logic txLoadHold;  // shifter <= holding register
    logic txShift;     // advance shifter one bit
    logic holdWrite;   // holding register <= parallel input
    logic rxClear;     // flush receiving state
    logic rxStart;     // first bit of a received word
    logic rxShift;     // further bit of a received word
    logic rxCommit;    // last bit: publish the word
  } lane_ctl_t;
endpackage

// File: rtl/duplex_serdes_ctrl.sv
`timescale 1ns/1ps
module duplex_serdes_ctrl import serdes12_pkg::*; #(
  parameter int W = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirIn,
  input  logic [1:0] selMode,
  input  logic       strobe,
  input  logic       serInClk,
  input  logic       serInFrame,
  output lane_ctl_t  ctl,
  output logic       txBusy,
  output logic       txFirst,
  output logic       wordClk,
  output logic       overrun,
  output logic       parOe
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

  logic          powerDown, txMode, rxMode, txLast, holdValid;
  logic [CW-1:0] txCnt, rxCnt;

  assign powerDown = (selMode == 2'b00);
  assign txMode    = !powerDown && dirIn;
  assign rxMode    = !powerDown && !dirIn;
  assign txLast    = txBusy && (txCnt == LAST_BIT);
  assign txFirst   = txBusy && (txCnt == '0);
  assign parOe     = rxMode;

  always_comb begin
    ctl = '0;
    if (!txMode) begin
      ctl.txClear = 1'b1;
    end else begin
      ctl.txShift = txBusy;
      if (txLast) begin
        if (holdValid)   ctl.txLoadHold = 1'b1;
        else if (strobe) ctl.txLoadPar  = 1'b1;
      end else if (!txBusy && strobe) begin
        ctl.txLoadPar = 1'b1;
      end
      ctl.holdWrite = strobe && txBusy && (txLast ? holdValid : !holdValid);
    end
    if (!rxMode) begin
      ctl.rxClear = 1'b1;
    end else if (serInClk) begin
      if (serInFrame) begin
        ctl.rxStart = 1'b1;
      end else if (rxCnt != '0) begin
        ctl.rxShift  = 1'b1;
        ctl.rxCommit = (rxCnt == LAST_BIT);
      end
    end
  end

  // Sending sequencer
  always_ff @(posedge clk) begin
    if (!rstN || ctl.txClear) begin
      txBusy    <= 1'b0;
      txCnt     <= '0;
      holdValid <= 1'b0;
    end else begin
      if (ctl.txLoadPar || ctl.txLoadHold) begin
        txBusy <= 1'b1;
        txCnt  <= '0;
      end else if (txLast) begin
        txBusy <= 1'b0;
        txCnt  <= '0;
      end else if (txBusy) begin
        txCnt <= txCnt + 1'b1;
      end
      if (ctl.holdWrite)       holdValid <= 1'b1;
      else if (ctl.txLoadHold) holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || powerDown)                                   overrun <= 1'b0;
    else if (txMode && strobe && txBusy && !txLast && holdValid) overrun <= 1'b1;
  end

  // Receiving bit counter
  always_ff @(posedge clk) begin
    if (!rstN || ctl.rxClear) rxCnt <= '0;
    else if (ctl.rxStart)     rxCnt <= CW'(1);
    else if (ctl.rxCommit)    rxCnt <= '0;
    else if (ctl.rxShift)     rxCnt <= rxCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wordClk <= 1'b0;
    else       wordClk <= (txMode && txLast) || ctl.rxCommit;
  end

  assert_hold_needs_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> txBusy);
  assert_pd_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!txBusy && !wordClk && rxCnt == '0));
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !powerDown) |=> overrun);
  assert_word_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordClk |=> !wordClk);
endmodule

// File: rtl/duplex_serdes_path.sv
`timescale 1ns/1ps
module duplex_serdes_path import serdes12_pkg::*; #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  lane_ctl_t    ctl,
  input  logic [W-1:0] parIn,
  input  logic         serIn,
  input  logic         txBusy,
  output logic         serOut,
  output logic [W-1:0] parOut
);
  logic [W-1:0] txSh, holdReg;
  logic [W-2:0] rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh    <= '0;
      holdReg <= '0;
    end else begin
      if (ctl.txClear)         txSh <= '0;
      else if (ctl.txLoadHold) txSh <= holdReg;
      else if (ctl.txLoadPar)  txSh <= parIn;
      else if (ctl.txShift)    txSh <= {txSh[W-2:0], 1'b0};
      if (ctl.txClear)         holdReg <= '0;
      else if (ctl.holdWrite)  holdReg <= parIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh   <= '0;
      parOut <= '0;
    end else begin
      if (ctl.rxClear)      rxSh <= '0;
      else if (ctl.rxStart) rxSh <= {{(W-2){1'b0}}, serIn};
      else if (ctl.rxShift) rxSh <= {rxSh[W-3:0], serIn};
      if (ctl.rxCommit)     parOut <= {rxSh, serIn};
    end
  end

  assign serOut = txBusy & txSh[W-1];

  assert_loads_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.txLoadHold && ctl.txLoadPar));
endmodule

// File: rtl/duplex_serdes.sv
`timescale 1ns/1ps
module duplex_serdes import serdes12_pkg::*; #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dirIn,
  input  logic [1:0]   selMode,
  input  logic         strobe,
  input  logic [W-1:0] parIn,
  output logic [W-1:0] parOut,
  output logic         parOe,
  output logic         serOut,
  output logic         serClkFwd,
  output logic         serFrame,
  input  logic         serIn,
  input  logic         serInClk,
  input  logic         serInFrame,
  output logic         wordClk,
  output logic         overrun,
  output logic         dirOut
);
  lane_ctl_t ctl;
  logic      txBusy, txFirst;

  duplex_serdes_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .dirIn(dirIn), .selMode(selMode), .strobe(strobe),
    .serInClk(serInClk), .serInFrame(serInFrame), .ctl(ctl), .txBusy(txBusy),
    .txFirst(txFirst), .wordClk(wordClk), .overrun(overrun), .parOe(parOe)
  );

  duplex_serdes_path #(.W(W)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .parIn(parIn), .serIn(serIn),
    .txBusy(txBusy), .serOut(serOut), .parOut(parOut)
  );

  assign serClkFwd = txBusy;
  assign serFrame  = txFirst;
  assign dirOut    = ~dirIn;

  assert_parout_hold_tx_R10: assert property (@(posedge clk) disable iff (!rstN)
    dirIn |=> $stable(parOut));
  assert_parout_hold_pd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selMode == 2'b00) |=> ($stable(parOut) && !serClkFwd && !overrun));
  assert_frame_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    serFrame |=> !serFrame);
endmodule

// File: tb/duplex_serdes_tb_top.sv
`timescale 1ns/1ps
module duplex_serdes_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, dirIn, strobe, serIn, serInClk, serInFrame;
  logic [1:0] selMode;
  logic [11:0] parIn, parOut;
  logic parOe, serOut, serClkFwd, serFrame, wordClk, overrun, dirOut;

  duplex_serdes dut_i (.*);

  int nChk = 0, nBad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Serial output collector
  int gotQ[$];
  int frameT[$];
  logic [11:0] acc = '0;
  int nb = 0;
  always @(negedge clk) if (rstN && serClkFwd) begin
    if (serFrame) begin acc = '0; nb = 0; frameT.push_back(cyc); end
    acc = {acc[10:0], serOut};
    nb++;
    if (nb == 12) begin gotQ.push_back(int'(acc)); nb = 0; end
  end

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Single word in the sending role, cycle-exact (R4, R5)
  task automatic txOne(input logic [11:0] w, input string tag);
    parIn = w; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    for (int i = 0; i < 12; i++) begin
      chk({tag, " R4 clk"}, serClkFwd, 1'b1);
      chk({tag, " R4 bit"}, serOut, w[11-i]);
      chk({tag, " R4 frame"}, serFrame, (i == 0));
      chk({tag, " R5 no pulse"}, wordClk, 1'b0);
      @(negedge clk);
    end
    chk({tag, " R4 idle"}, serClkFwd, 1'b0);
    chk({tag, " R5 pulse"}, wordClk, 1'b1);
    @(negedge clk);
    chk({tag, " R5 one cycle"}, wordClk, 1'b0);
  endtask

  // Receiving: send bits, optional junk gaps
  task automatic rxBits(input logic [11:0] w, input int n, input bit framed, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        int g = $urandom % 3;
        for (int k = 0; k < g; k++) begin
          serInClk = 1'b0; serIn = $urandom; serInFrame = $urandom;
          @(negedge clk);
        end
      end
      serInClk = 1'b1; serIn = w[11-i]; serInFrame = framed && (i == 0);
      @(negedge clk);
    end
    serInClk = 1'b0; serInFrame = 1'b0;
  endtask

  task automatic rxWordChk(input logic [11:0] w, input bit gaps, input string tag);
    rxBits(w, 12, 1'b1, gaps);
    chk({tag, " R8 word"}, parOut, w);
    chk({tag, " R5 rx pulse"}, wordClk, 1'b1);
    @(negedge clk);
    chk({tag, " R5 rx one cycle"}, wordClk, 1'b0);
  endtask

  initial begin
    int unsigned seed;
    logic [11:0] ref0, ref1;
    int expQ[$];
    int sent;
    bit seen;
    seed = $urandom(32'h5EED_1234);
    rstN = 0; dirIn = 0; selMode = 2'b01; strobe = 0; parIn = '0;
    serIn = 0; serInClk = 0; serInFrame = 0;
    #1 chk("R1 inverse in reset", dirOut, 1'b1);
    waitN(3);
    rstN = 1;
    @(negedge clk);
    chk("R10 reset parOut", parOut, 12'h000);
    chk("R4 reset idle", serClkFwd, 1'b0);
    chk("R5 reset pulse", wordClk, 1'b0);
    chk("R7 reset overrun", overrun, 1'b0);
    chk("R3 oe receiving", parOe, 1'b1);

    // R1, R3 across codes
    for (int m = 0; m < 4; m++) begin
      selMode = m[1:0];
      dirIn = 1'b1; #1;
      chk("R1 dir high", dirOut, 1'b0);
      chk("R3 oe sending", parOe, 1'b0);
      dirIn = 1'b0; #1;
      chk("R1 dir low", dirOut, 1'b1);
      chk("R3 oe by code", parOe, (m != 0));
    end
    @(negedge clk);

    // R4/R5/R11: one word per operating code
    dirIn = 1'b1;
    selMode = 2'b01; @(negedge clk); txOne(12'hA5C, "c01 R11");
    selMode = 2'b10; @(negedge clk); txOne(12'h801, "c10 R11");
    selMode = 2'b11; @(negedge clk); txOne(12'h7FE, "c11 R11");

    // R6/R7: queue and overrun
    gotQ.delete(); frameT.delete();
    parIn = 12'h123; strobe = 1; @(negedge clk);
    parIn = 12'h456; @(negedge clk);
    parIn = 12'h789; @(negedge clk);
    strobe = 0;
    waitN(30);
    chk("R6 two words", gotQ.size(), 2);
    if (gotQ.size() == 2) begin
      chk("R6 first word", gotQ[0], 12'h123);
      chk("R7 third dropped", gotQ[1], 12'h456);
      chk("R6 no gap", frameT[1] - frameT[0], 12);
    end
    chk("R7 overrun set", overrun, 1'b1);
    waitN(5);
    chk("R7 overrun sticky", overrun, 1'b1);
    selMode = 2'b00; @(negedge clk);
    chk("R7 cleared by power-down", overrun, 1'b0);
    selMode = 2'b11; @(negedge clk);

    // R7 last-bit boundary: no overrun, three words in order
    gotQ.delete(); frameT.delete();
    parIn = 12'hAAA; strobe = 1; @(negedge clk);
    parIn = 12'h555; @(negedge clk);
    strobe = 0;
    waitN(10);
    parIn = 12'hF0F; strobe = 1; @(negedge clk);
    strobe = 0;
    waitN(40);
    chk("R7 last-bit words", gotQ.size(), 3);
    if (gotQ.size() == 3) begin
      chk("R7 w0", gotQ[0], 12'hAAA);
      chk("R7 w1", gotQ[1], 12'h555);
      chk("R7 w2", gotQ[2], 12'hF0F);
      chk("R6 gap 2", frameT[2] - frameT[1], 12);
    end
    chk("R7 no overrun at last bit", overrun, 1'b0);

    // R12: abort by turnaround with a queued word
    parIn = 12'h3C3; strobe = 1; @(negedge clk);
    parIn = 12'hC3C; @(negedge clk);
    strobe = 0; waitN(3);
    dirIn = 0; @(negedge clk);
    chk("R12 aborted", serClkFwd, 1'b0);
    seen = 0;
    for (int i = 0; i < 14; i++) begin if (wordClk) seen = 1; @(negedge clk); end
    dirIn = 1;
    for (int i = 0; i < 14; i++) begin if (serClkFwd || wordClk) seen = 1; @(negedge clk); end
    chk("R12 nothing resumes", seen, 1'b0);

    // R2: power-down ignores strobe
    selMode = 2'b00; parIn = 12'hFFF; strobe = 1; @(negedge clk); strobe = 0;
    seen = 0;
    for (int i = 0; i < 14; i++) begin if (serClkFwd || serFrame || wordClk || serOut || parOe) seen = 1; @(negedge clk); end
    chk("R2 send quiet", seen, 1'b0);

    // R8 receive, R5 pulse
    selMode = 2'b01; dirIn = 0; @(negedge clk);
    rxWordChk(12'hB2D, 1'b0, "plain");
    rxWordChk(12'h4E1, 1'b1, "gaps");
    ref0 = 12'h4E1;

    // R9: stray bits then a word; restart in mid-word
    rxBits(12'hFFF, 5, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 stray ignored", parOut, ref0);
    rxWordChk(12'h0F1, 1'b0, "after stray R9");
    rxBits(12'hABC, 6, 1'b1, 1'b0);
    chk("R9 partial no pulse", wordClk, 1'b0);
    rxWordChk(12'h5A6, 1'b1, "restart R9");
    ref1 = 12'h5A6;

    // R10: hold through sending role and power-down
    dirIn = 1; @(negedge clk);
    txOne(12'h0FF, "hold R10");
    chk("R10 held in sending", parOut, ref1);
    selMode = 2'b00; dirIn = 0;
    rxBits(12'h999, 12, 1'b1, 1'b0);
    @(negedge clk);
    chk("R2 rx ignored in power-down", parOut, ref1);
    chk("R2 no rx pulse", wordClk, 1'b0);
    selMode = 2'b10; @(negedge clk);
    rxBits(12'h777, 7, 1'b1, 1'b0);
    chk("R10 partial keeps word", parOut, ref1);
    rxWordChk(12'h246, 1'b0, "overwrite R10");

    // Random sending traffic against a bench queue (R4, R6)
    dirIn = 1; selMode = 2'b11; @(negedge clk);
    gotQ.delete(); sent = 0;
    for (int i = 0; i < 400; i++) begin
      #1;
      if ((sent - gotQ.size()) < 2 && ($urandom % 3 == 0)) begin
        parIn = $urandom; strobe = 1; expQ.push_back(int'(parIn)); sent++;
      end else begin
        strobe = 0; parIn = $urandom;
      end
      @(negedge clk);
    end
    strobe = 0; waitN(40);
    chk("R4 random count", gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      chk("R4 random word", gotQ[i], expQ[i]);
    chk("R7 random no overrun", overrun, 1'b0);

    // Random receiving words (R8)
    dirIn = 0; selMode = 2'b01; @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      logic [11:0] w;
      w = $urandom;
      rxWordChk(w, 1'b1, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule